// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the controller clock into time quanta and walks each nominal bit through four segments: a one-quantum synchronisation slot, a propagation slot, a first phase buffer and a second phase buffer. It strobes the transmit point once per bit, at the end of the synchronisation quantum. It strobes the sample point where the first phase buffer hands over to the second. The surrounding controller uses the transmit strobe to launch the next bit onto the bus and the sample strobe to capture the received level.

Timing fields are plain parallel inputs. They are copied into shadow registers on every clock while `enable` is low and frozen while it is high. A programmed bit length outside 8 to 25 quanta raises `cfg_err` and keeps the timing idle. A recessive-to-dominant edge indication from the receive path realigns the bit. When the bus is idle the edge forces a hard restart. Otherwise a late edge stretches phase 1 and an early edge trims phase 2. The adjustment is limited to the jump width, and only one is applied per bit.

The segment state machine has four named states: SYNC (code 0), PROP (1), PHASE1 (2) and PHASE2 (3). On the quantum that ends a state it moves SYNC to PROP, PROP to PHASE1, PHASE1 to PHASE2, and PHASE2 to SYNC. A hard-sync restart or an early-edge restart moves any state to SYNC. Disable, or a configuration error, holds the machine in SYNC.

Top module: `can_bit_timer`

## Requirements
- R1: While running, `tq_tick` pulses for one clock every (`cfg_brp`+1) clocks, so one quantum lasts (`cfg_brp`+1) clock periods.
- R2: `seg` shows the current segment, encoded SYNC=0, PROP=1, PHASE1=2, PHASE2=3. The segments run in that order and last 1, `cfg_prop`+1, `cfg_ph1`+1 and `cfg_ph2`+1 quanta, so an undisturbed bit holds prop+ph1+ph2+4 quanta.
- R3: `sample_pt` coincides with the quantum tick that ends PHASE1. Without realignment it comes (`cfg_brp`+1)*(`cfg_prop`+`cfg_ph1`+2) clocks after `tx_pt`.
- R4: `tx_pt` coincides with the quantum tick of the SYNC segment, once per bit. Without realignment the interval between `tx_pt` pulses is (`cfg_brp`+1) times the quanta per bit.
- R5: `cfg_err` is high when prop+ph1+ph2+4 is below 8 or above 25. While it is high, no quantum tick, sample or transmit strobe is produced and `seg` stays 0.
- R6: Timing fields are taken only while `enable` is low. Changes made while `enable` is high affect neither `cfg_err` nor the bit length.
- R7: A `rx_edge` pulse while `bus_idle` is high restarts the bit: the next clock is the first clock of SYNC, and the prescaler restarts.
- R8: A soft edge in PROP or PHASE1 lengthens PHASE1 by min(e, `cfg_sjw`+1) quanta. Here e is the 1-based index of the quantum holding the edge, counted from the end of SYNC.
- R9: A soft edge in PHASE2 computes e as the number of PHASE2 quanta left, counting the current one. If e is at most `cfg_sjw`+1, the bit restarts at SYNC on the next clock. Otherwise PHASE2 is shortened by `cfg_sjw`+1 quanta.
- R10: Only the first soft edge in a bit is acted on. Later soft edges in the same bit do not change its length.
- R11: Soft edges that arrive during SYNC are ignored.
- R12: During reset all strobes are low and `seg` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the timing when high; latches the fields when low |
| cfg_brp | input | 6 | Prescaler field; quantum = value+1 clocks |
| cfg_prop | input | 3 | Propagation segment field; length = value+1 quanta |
| cfg_ph1 | input | 3 | Phase 1 field; length = value+1 quanta |
| cfg_ph2 | input | 3 | Phase 2 field; length = value+1 quanta |
| cfg_sjw | input | 2 | Jump width field; limit = value+1 quanta |
| bus_idle | input | 1 | Bus idle; turns an edge into a hard restart |
| rx_edge | input | 1 | One-clock pulse on a recessive-to-dominant bus edge |
| tq_tick | output | 1 | Time-quantum strobe (last clock of each quantum) |
| sample_pt | output | 1 | Sample-point strobe |
| tx_pt | output | 1 | Transmit-point strobe |
| seg | output | 2 | Current segment code |
| cfg_err | output | 1 | Programmed bit length outside 8..25 quanta |

## Verification
Eight field sets are each run for one undisturbed bit. The interval between transmit strobes, the sample offset and the number of quantum ticks per bit together separate a wrong prescaler from a wrong segment length. Two of the sets sit at the 8-quantum lower bound and the 25-quantum upper bound. Two fall below 8 and must leave the timing silent. With one fixed field set, edges are injected at chosen quantum indices: the first propagation quantum, the first PHASE1 quantum beyond the jump width, each of the first two PHASE2 quanta, inside SYNC, a second edge in the same bit, and an edge while the bus is idle. The resulting bit length tells lengthening, clamping, shortening, immediate restart and rejection apart. A last test changes the fields while running to show that the frozen values are kept.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_PROP   = 2'd1,
        SEG_PHASE1 = 2'd2,
        SEG_PHASE2 = 2'd3
    } seg_e;
endpackage

// File: rtl/cbt_cfg_latch.sv
`timescale 1ns/1ps
module cbt_cfg_latch #(
    parameter int BRP_W  = 6,
    parameter int SEG_W  = 3,
    parameter int SJW_W  = 2,
    parameter int MIN_TQ = 8,
    parameter int MAX_TQ = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [BRP_W-1:0] in_brp,
    input  logic [SEG_W-1:0] in_prop,
    input  logic [SEG_W-1:0] in_ph1,
    input  logic [SEG_W-1:0] in_ph2,
    input  logic [SJW_W-1:0] in_sjw,
    output logic [BRP_W-1:0] q_brp,
    output logic [SEG_W-1:0] q_prop,
    output logic [SEG_W-1:0] q_ph1,
    output logic [SEG_W-1:0] q_ph2,
    output logic [SJW_W-1:0] q_sjw,
    output logic             bad_len
);
    localparam int TOT_W = SEG_W + 3;
    localparam logic [TOT_W-1:0] LO_T = TOT_W'(MIN_TQ);
    localparam logic [TOT_W-1:0] HI_T = TOT_W'(MAX_TQ);

    logic [TOT_W-1:0] total;

    // Shadow copy follows the inputs only while the timing is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_brp  <= '0;
            q_prop <= '0;
            q_ph1  <= '0;
            q_ph2  <= '0;
            q_sjw  <= '0;
        end else if (!enable) begin
            q_brp  <= in_brp;
            q_prop <= in_prop;
            q_ph1  <= in_ph1;
            q_ph2  <= in_ph2;
            q_sjw  <= in_sjw;
        end
    end

    // Four fields each add one quantum: sync (fixed), prop, phase1, phase2.
    always_comb begin
        total   = TOT_W'(q_prop) + TOT_W'(q_ph1) + TOT_W'(q_ph2) + TOT_W'(4);
        bad_len = (total < LO_T) || (total > HI_T);
    end
endmodule

// File: rtl/cbt_tq_prescaler.sv
`timescale 1ns/1ps
module cbt_tq_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    logic [BRP_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || restart) begin
            div_q <= '0;
        end else if (div_q == brp) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + BRP_W'(1);
        end
    end

    assign tq_tick = run && (div_q == brp);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && brp != '0) |=> !tq_tick); // R1
endmodule

// File: rtl/cbt_seg_fsm.sv
`timescale 1ns/1ps
module cbt_seg_fsm
    import cbt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tq_tick,
    input  logic             rx_edge,
    input  logic             bus_idle,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    output seg_e             seg,
    output logic             sample_pt,
    output logic             tx_pt,
    output logic             restart
);
    // One width holds every length, count and phase error (max prop+ph1 = 16).
    localparam int CW = SEG_W + 2;

    seg_e            st_q, st_nx;
    logic [CW-1:0]   q_q;
    logic [CW-1:0]   ext_q, ext_n;
    logic [CW-1:0]   shrt_q, shrt_n;
    logic            done_q;

    logic [CW-1:0]   prop_len, ph1_len, ph2_len, sjw_len;
    logic [CW-1:0]   seg_len, e_late, e_early;
    logic            edge_ok, hard, early_rs, late_side, last;

    // Realignment and segment length
    always_comb begin
        prop_len  = CW'(cfg_prop) + CW'(1);
        ph1_len   = CW'(cfg_ph1)  + CW'(1);
        ph2_len   = CW'(cfg_ph2)  + CW'(1);
        sjw_len   = CW'(cfg_sjw)  + CW'(1);
        late_side = (st_q == SEG_PROP) || (st_q == SEG_PHASE1);
        hard      = run && rx_edge && bus_idle;
        edge_ok   = run && rx_edge && !bus_idle && !done_q && (st_q != SEG_SYNC);
        e_late    = (st_q == SEG_PROP) ? (q_q + CW'(1)) : (prop_len + q_q + CW'(1));
        e_early   = ph2_len - q_q;
        early_rs  = edge_ok && (st_q == SEG_PHASE2) && (e_early <= sjw_len);
        ext_n     = ext_q;
        shrt_n    = shrt_q;
        if (edge_ok && late_side) begin
            ext_n = (e_late < sjw_len) ? e_late : sjw_len;
        end
        if (edge_ok && (st_q == SEG_PHASE2) && !early_rs) begin
            shrt_n = sjw_len;
        end
        unique case (st_q)
            SEG_SYNC:   seg_len = CW'(1);
            SEG_PROP:   seg_len = prop_len;
            SEG_PHASE1: seg_len = ph1_len + ext_n;
            SEG_PHASE2: seg_len = ph2_len - shrt_n;
        endcase
        last    = (q_q == seg_len - CW'(1));
        restart = hard || early_rs;
        unique case (st_q)
            SEG_SYNC:   st_nx = SEG_PROP;
            SEG_PROP:   st_nx = SEG_PHASE1;
            SEG_PHASE1: st_nx = SEG_PHASE2;
            SEG_PHASE2: st_nx = SEG_SYNC;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SEG_SYNC;
            q_q    <= '0;
            ext_q  <= '0;
            shrt_q <= '0;
            done_q <= 1'b0;
        end else if (!run || restart) begin
            st_q   <= SEG_SYNC;
            q_q    <= '0;
            ext_q  <= '0;
            shrt_q <= '0;
            done_q <= 1'b0;
        end else begin
            ext_q  <= ext_n;
            shrt_q <= shrt_n;
            if (edge_ok) begin
                done_q <= 1'b1;
            end
            if (tq_tick) begin
                if (last) begin
                    st_q <= st_nx;
                    q_q  <= '0;
                end else begin
                    q_q  <= q_q + CW'(1);
                end
                if (st_q == SEG_SYNC) begin
                    ext_q  <= '0;
                    shrt_q <= '0;
                    done_q <= 1'b0;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        seg       = st_q;
        tx_pt     = tq_tick && (st_q == SEG_SYNC);
        sample_pt = tq_tick && (st_q == SEG_PHASE1) && last;
    end

    AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q) && st_q != SEG_SYNC) |-> (2'(st_q) == 2'($past(st_q)) + 2'd1)); // R2
    AST_SAMPLE_TO_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pt && !(rx_edge && bus_idle)) |=> (st_q == SEG_PHASE2)); // R3
    AST_HARD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rx_edge && bus_idle) |=> (st_q == SEG_SYNC && q_q == '0)); // R7
    AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q <= sjw_len); // R8
    AST_SHRT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (shrt_q <= sjw_len) && (shrt_q < ph2_len || shrt_q == '0)); // R9
    AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && done_q && !(tq_tick && st_q == SEG_SYNC) && !(rx_edge && bus_idle))
        |=> ($stable(ext_q) && $stable(shrt_q))); // R10
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int BRP_W  = 6,
    parameter int SEG_W  = 3,
    parameter int SJW_W  = 2,
    parameter int MIN_TQ = 8,
    parameter int MAX_TQ = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_prop,
    input  logic [SEG_W-1:0] cfg_ph1,
    input  logic [SEG_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             bus_idle,
    input  logic             rx_edge,
    output logic             tq_tick,
    output logic             sample_pt,
    output logic             tx_pt,
    output logic [1:0]       seg,
    output logic             cfg_err
);
    logic [BRP_W-1:0] l_brp;
    logic [SEG_W-1:0] l_prop, l_ph1, l_ph2;
    logic [SJW_W-1:0] l_sjw;
    logic             run, restart;
    seg_e             seg_s;

    cbt_cfg_latch #(
        .BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W),
        .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .in_brp(cfg_brp), .in_prop(cfg_prop), .in_ph1(cfg_ph1),
        .in_ph2(cfg_ph2), .in_sjw(cfg_sjw),
        .q_brp(l_brp), .q_prop(l_prop), .q_ph1(l_ph1),
        .q_ph2(l_ph2), .q_sjw(l_sjw), .bad_len(cfg_err)
    );

    assign run = enable && !cfg_err;

    cbt_tq_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .brp(l_brp), .tq_tick(tq_tick)
    );

    cbt_seg_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick),
        .rx_edge(rx_edge), .bus_idle(bus_idle),
        .cfg_prop(l_prop), .cfg_ph1(l_ph1), .cfg_ph2(l_ph2), .cfg_sjw(l_sjw),
        .seg(seg_s), .sample_pt(sample_pt), .tx_pt(tx_pt), .restart(restart)
    );

    assign seg = seg_s;

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!tq_tick && !sample_pt && !tx_pt && seg == 2'd0)); // R5
    AST_TX_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pt && !(rx_edge && bus_idle)) |=> !tx_pt || (seg == 2'd0 && $past(cfg_brp) == cfg_brp && !enable)); // R4
endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic       bus_idle = 1'b0, rx_edge = 1'b0;
    logic [5:0] cfg_brp = '0;
    logic [2:0] cfg_prop = '0, cfg_ph1 = '0, cfg_ph2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       tq_tick, sample_pt, tx_pt, cfg_err;
    logic [1:0] seg;

    can_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1),
        .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
        .bus_idle(bus_idle), .rx_edge(rx_edge),
        .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt),
        .seg(seg), .cfg_err(cfg_err)
    );

    always #HALF clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    int segs [0:15];

    // {exp_err, brp[5:0], prop[2:0], ph1[2:0], ph2[2:0], sjw[1:0]}
    localparam logic [17:0] VEC [0:7] = '{
        {1'b0, 6'd0,  3'd1, 3'd2, 3'd2, 2'd1},
        {1'b0, 6'd3,  3'd2, 3'd1, 3'd1, 2'd0},
        {1'b0, 6'd1,  3'd7, 3'd7, 3'd7, 2'd3},
        {1'b0, 6'd63, 3'd7, 3'd7, 3'd7, 2'd3},
        {1'b1, 6'd0,  3'd0, 3'd0, 3'd0, 2'd0},
        {1'b1, 6'd1,  3'd1, 3'd1, 3'd1, 2'd0},
        {1'b0, 6'd5,  3'd4, 3'd0, 3'd3, 2'd2},
        {1'b0, 6'd0,  3'd2, 3'd1, 3'd1, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [16:0] v);
        @(posedge clk); #1;
        enable = 1'b0;
        {cfg_brp, cfg_prop, cfg_ph1, cfg_ph2, cfg_sjw} = v;
        @(posedge clk); #1;
        enable = 1'b1;
    endtask

    task automatic wait_tx(output int c0);
        int n;
        n = 0;
        @(negedge clk);
        while (!tx_pt && n < 6000) begin
            @(negedge clk);
            n++;
        end
        c0 = cyc;
    endtask

    // Called at the negedge where tx_pt was seen (bit index 0); runs until the next tx_pt.
    task automatic run_bit(input int c0, input int k, input int k2, input bit idle,
                           output int per, output int smp, output int ticks);
        int i;
        smp   = -1;
        per   = -1;
        ticks = tq_tick ? 1 : 0;
        segs[0] = int'(seg);
        rx_edge  = (k == 0) || (k2 == 0);
        bus_idle = idle && (k == 0);
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #1;
            i = cyc - c0;
            rx_edge  = (i == k) || (i == k2);
            bus_idle = idle && (i == k);
            @(negedge clk);
            if (i < 16) segs[i] = int'(seg);
            if (tx_pt) begin
                per = i;
                break;
            end
            if (tq_tick) ticks++;
            if (sample_pt && smp < 0) smp = i;
        end
        rx_edge  = 1'b0;
        bus_idle = 1'b0;
    endtask

    task automatic rs_case(inout int c0, input int k, input int k2, input bit idle,
                           input int eper, input int esmp, input string req);
        int per, smp, tk;
        run_bit(c0, k, k2, idle, per, smp, tk);
        chk(per == eper, {req, " bit length"}, per, eper);
        chk(smp == esmp, {req, " sample offset"}, smp, esmp);
        c0 = cyc;
    endtask

    initial begin
        int c0, per, smp, tk, tot, q, t;
        logic [17:0] e;
        {cfg_brp, cfg_prop, cfg_ph1, cfg_ph2, cfg_sjw} = VEC[0][16:0];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(!tq_tick && !tx_pt && !sample_pt, "R12 strobes in reset", int'(tq_tick | tx_pt | sample_pt), 0);
        chk(seg == 2'd0, "R12 seg in reset", int'(seg), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R6 fields taken while disabled", int'(cfg_err), 0);
        chk(tq_tick == 1'b0, "R1 no tick while disabled", int'(tq_tick), 0);

        // Vector walk: one undisturbed bit per field set
        for (int v = 0; v < 8; v++) begin
            e   = VEC[v];
            tot = int'(e[10:8]) + int'(e[7:5]) + int'(e[4:2]) + 4;
            q   = int'(e[16:11]) + 1;
            load_cfg(e[16:0]);
            @(negedge clk);
            chk(cfg_err == e[17], "R5 length check", int'(cfg_err), int'(e[17]));
            if (e[17]) begin
                t = 0;
                for (int j = 0; j < 80; j++) begin
                    @(negedge clk);
                    if (tq_tick || tx_pt || sample_pt || seg != 2'd0) t++;
                end
                chk(t == 0, "R5 timing idle on error", t, 0);
            end else begin
                wait_tx(c0);
                run_bit(c0, -1, -1, 1'b0, per, smp, tk);
                chk(per == q * tot, "R4 R1 tx interval", per, q * tot);
                chk(smp == q * (int'(e[10:8]) + int'(e[7:5]) + 2), "R3 sample offset",
                    smp, q * (int'(e[10:8]) + int'(e[7:5]) + 2));
                chk(tk == tot, "R2 quanta per bit", tk, tot);
            end
        end

        // Realignment with brp=0, prop 2q, ph1 3q, ph2 3q, sjw 2q (9-clock bit)
        load_cfg(VEC[0][16:0]);
        wait_tx(c0);
        run_bit(c0, -1, -1, 1'b0, per, smp, tk);
        chk(segs[1] == 1 && segs[3] == 2 && segs[6] == 3, "R2 segment codes",
            segs[1] * 100 + segs[3] * 10 + segs[6], 123);
        c0 = cyc;
        rs_case(c0,  1, -1, 1'b0, 10, 6,  "R8 late edge in PROP");
        rs_case(c0,  3, -1, 1'b0, 11, 7,  "R8 late edge clamped");
        rs_case(c0, -1, -1, 1'b0,  9, 5,  "R8 next bit back to nominal");
        rs_case(c0,  1,  3, 1'b0, 10, 6,  "R10 second edge ignored");
        rs_case(c0,  0, -1, 1'b0,  9, 5,  "R11 edge in SYNC ignored");
        rs_case(c0,  6, -1, 1'b0,  7, 5,  "R9 early edge shortens");
        rs_case(c0,  7, -1, 1'b0,  8, 5,  "R9 early edge restarts");
        rs_case(c0,  4, -1, 1'b1,  5, -1, "R7 hard sync");

        // R6: field changes while running are not taken
        @(posedge clk); #1;
        cfg_brp = 6'd9; cfg_prop = 3'd0; cfg_ph1 = 3'd0; cfg_ph2 = 3'd0;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R6 cfg_err frozen while enabled", int'(cfg_err), 0);
        wait_tx(c0);
        run_bit(c0, -1, -1, 1'b0, per, smp, tk);
        chk(per == 9, "R6 bit length frozen while enabled", per, 9);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(2 * HALF * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule